// File: doc/BRIEF.md
# Sixteen-Bit Grouped-Opcode Arithmetic and Logic Unit

This block is the arithmetic and logic stage of a small 16-bit RISC datapath. Two operands, a five-bit operation selector and a carry input go in. A result word, a carry output and an overflow/validity flag come out. All three outputs are registered, so they follow the inputs by one clock.

The two upper selector bits pick one of four operation families: bitwise logic, signed comparison, addition/subtraction, or shifting. The three lower bits pick the operation within that family. The sub-code assignment is sparse and differs from family to family. The arithmetic family holds signed and unsigned variants, which share one adder and differ only in how the flag is formed.

A selector value that names no operation produces an all-zero result with both flags cleared.

Top module: `alu16_core`

## Requirements
- R1: A synchronous active-high `rst` clears `result`, `carry_out` and `flag_v` at the next rising edge. Otherwise, the outputs at each rising edge reflect the inputs present just before that edge.
- R2: `op_sel[4:3]` selects the family: 00 logic, 01 compare, 10 arithmetic, 11 shift. `op_sel[2:0]` selects the operation within the family.
- R3: Logic sub-codes: 111 gives `op_a | op_b`, 011 gives `op_a ^ op_b`, 101 gives `op_a & op_b`, and 000 gives `~op_a`.
- R4: Compare sub-codes treat both operands as two's-complement. They are 001 less-than, 100 less-or-equal, 011 greater-than, 110 greater-or-equal, 111 equal and 010 not-equal. The result is 16'h0001 when the condition holds and 16'h0000 when it does not.
- R5: Sub-code 101 (signed add) and sub-code 001 (unsigned add) give `op_a + op_b + carry_in`. `carry_out` is the carry out of bit 15. For 101, `flag_v` is the two's-complement overflow. For 001, `flag_v` equals `carry_out`.
- R6: Sub-code 100 (signed subtract) and sub-code 000 (unsigned subtract) give `op_a + ~op_b + 1`, and `carry_in` is ignored. `carry_out` is the carry out of bit 15, which is 1 when `op_a >= op_b` unsigned. For 100, `flag_v` is the signed overflow. For 000, `flag_v` is the borrow (`op_a < op_b` unsigned).
- R7: Sub-code 111 gives `op_a + 1` and sub-code 110 gives `op_a - 1` (computed as `op_a + 16'hFFFF`). For both, `carry_in` and `op_b` are ignored. `carry_out` is the bit-15 carry: 1 only for increment of 16'hFFFF, and 1 for every decrement except of 0. `flag_v` is set only for increment of 16'h7FFF and for decrement of 16'h8000.
- R8: Shift sub-codes move `op_a` by `op_b[3:0]`, and `op_b[15:4]` is ignored. The sub-codes are 010 logical left, 100 arithmetic left (zero fill), 011 logical right, 101 arithmetic right (sign fill), 000 rotate left (bit 15 wraps to bit 0) and 001 rotate right (bit 0 wraps to bit 15).
- R9: For arithmetic left shift, `flag_v` is 1 exactly when `op_a * 2^n` does not fit a signed 16-bit value. For all other shifts, `flag_v` is 0.
- R10: `carry_out` is 0 outside the arithmetic family. `flag_v` is 0 in the logic and compare families, whatever `carry_in` is.
- R11: Undefined sub-codes give `result` = 0, `carry_out` = 0 and `flag_v` = 0. These are logic 001/010/100/110, compare 000/101, arithmetic 010/011 and shift 110/111.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| op_a | input | 16 | First operand |
| op_b | input | 16 | Second operand, or the shift amount in bits [3:0] |
| op_sel | input | 5 | Family in [4:3], operation in [2:0] |
| carry_in | input | 1 | Carry added by the two add operations |
| result | output | 16 | Registered result word |
| carry_out | output | 1 | Registered carry out of bit 15 |
| flag_v | output | 1 | Registered overflow, carry or borrow flag |

## Verification
The bound checker watches several rules on every cycle. It checks the clearing by reset, the zero carry outside arithmetic, the single-bit result and clear flag of the compare family, the all-zero response to undefined codes, and complement and equality results one cycle after their inputs. It also checks that rotation preserves the bit count and that the unsigned-add flag matches the carry. The exact arithmetic values, the signed/unsigned flag rules at the operand extremes, the fill bits and wrap of each shift, and the left-shift overflow flag are shown only by the bench. The bench drives every selector value against corner and random operands and compares the results with its reference model.

// File: rtl/alu16_pkg.sv
package alu16_pkg;

  typedef enum logic [1:0] {
    GRP_LOGIC = 2'b00,
    GRP_CMP   = 2'b01,
    GRP_ARITH = 2'b10,
    GRP_SHIFT = 2'b11
  } grp_e;

  // logic family
  localparam logic [2:0] LG_NOTA = 3'b000;
  localparam logic [2:0] LG_XOR  = 3'b011;
  localparam logic [2:0] LG_AND  = 3'b101;
  localparam logic [2:0] LG_OR   = 3'b111;

  // compare family
  localparam logic [2:0] CM_LT = 3'b001;
  localparam logic [2:0] CM_NE = 3'b010;
  localparam logic [2:0] CM_GT = 3'b011;
  localparam logic [2:0] CM_LE = 3'b100;
  localparam logic [2:0] CM_GE = 3'b110;
  localparam logic [2:0] CM_EQ = 3'b111;

  // arithmetic family
  localparam logic [2:0] AR_SUBU = 3'b000;
  localparam logic [2:0] AR_ADDU = 3'b001;
  localparam logic [2:0] AR_SUB  = 3'b100;
  localparam logic [2:0] AR_ADD  = 3'b101;
  localparam logic [2:0] AR_DEC  = 3'b110;
  localparam logic [2:0] AR_INC  = 3'b111;

  // shift family
  localparam logic [2:0] SH_ROL = 3'b000;
  localparam logic [2:0] SH_ROR = 3'b001;
  localparam logic [2:0] SH_LSL = 3'b010;
  localparam logic [2:0] SH_LSR = 3'b011;
  localparam logic [2:0] SH_ASL = 3'b100;
  localparam logic [2:0] SH_ASR = 3'b101;

endpackage

// File: rtl/alu16_logic_unit.sv
module alu16_logic_unit
  import alu16_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [2:0]   sub,
  output logic [W-1:0] y,
  output logic         hit
);
  always_comb begin
    hit = 1'b1;
    case (sub)
      LG_OR:   y = a | b;
      LG_XOR:  y = a ^ b;
      LG_AND:  y = a & b;
      LG_NOTA: y = ~a;
      default: begin
        y   = '0;
        hit = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/alu16_cmp_unit.sv
module alu16_cmp_unit
  import alu16_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [2:0]   sub,
  output logic [W-1:0] y,
  output logic         hit
);
  logic lt, eq, cond;

  assign lt = $signed(a) < $signed(b);
  assign eq = (a == b);

  always_comb begin
    hit = 1'b1;
    case (sub)
      CM_LT:   cond = lt;
      CM_LE:   cond = lt | eq;
      CM_GT:   cond = ~(lt | eq);
      CM_GE:   cond = ~lt;
      CM_EQ:   cond = eq;
      CM_NE:   cond = ~eq;
      default: begin
        cond = 1'b0;
        hit  = 1'b0;
      end
    endcase
  end

  assign y = {{(W-1){1'b0}}, cond};
endmodule

// File: rtl/alu16_arith_unit.sv
module alu16_arith_unit
  import alu16_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  input  logic [2:0]   sub,
  output logic [W-1:0] y,
  output logic         cout,
  output logic         v,
  output logic         hit
);
  logic [W-1:0] b_eff;
  logic         c0, sgn, brw, ovf;
  logic [W:0]   sum;

  always_comb begin
    hit   = 1'b1;
    sgn   = 1'b0;
    brw   = 1'b0;
    b_eff = b;
    c0    = cin;
    case (sub)
      AR_ADD:  sgn = 1'b1;
      AR_ADDU: sgn = 1'b0;
      AR_SUB:  begin b_eff = ~b; c0 = 1'b1; sgn = 1'b1; end
      AR_SUBU: begin b_eff = ~b; c0 = 1'b1; brw = 1'b1; end
      AR_INC:  begin b_eff = '0; c0 = 1'b1; sgn = 1'b1; end
      AR_DEC:  begin b_eff = '1; c0 = 1'b0; sgn = 1'b1; end
      default: begin b_eff = '0; c0 = 1'b0; hit = 1'b0; end
    endcase
  end

  // single shared adder for every variant
  assign sum  = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, c0};
  assign ovf  = (a[W-1] == b_eff[W-1]) && (sum[W-1] != a[W-1]);
  assign y    = sum[W-1:0];
  assign cout = sum[W];
  assign v    = sgn ? ovf : (brw ? ~sum[W] : sum[W]);
endmodule

// File: rtl/alu16_shift_unit.sv
module alu16_shift_unit
  import alu16_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0]         a,
  input  logic [$clog2(W)-1:0] amt,
  input  logic [2:0]           sub,
  output logic [W-1:0]         y,
  output logic                 v,
  output logic                 hit
);
  localparam int SHW = $clog2(W);

  logic [W-1:0] stg [0:SHW];
  assign stg[0] = a;

  for (genvar s = 0; s < SHW; s++) begin : g_stage
    localparam int K = 1 << s;
    logic [W-1:0] sh;
    always_comb begin
      case (sub)
        SH_LSL, SH_ASL: sh = {stg[s][W-1-K:0], {K{1'b0}}};
        SH_LSR:         sh = {{K{1'b0}}, stg[s][W-1:K]};
        SH_ASR:         sh = {{K{stg[s][W-1]}}, stg[s][W-1:K]};
        SH_ROL:         sh = {stg[s][W-1-K:0], stg[s][W-1:W-K]};
        SH_ROR:         sh = {stg[s][K-1:0], stg[s][W-1:K]};
        default:        sh = stg[s];
      endcase
    end
    assign stg[s+1] = amt[s] ? sh : stg[s];
  end

  always_comb begin
    case (sub)
      SH_LSL, SH_ASL, SH_LSR, SH_ASR, SH_ROL, SH_ROR: hit = 1'b1;
      default:                                        hit = 1'b0;
    endcase
  end

  assign y = hit ? stg[SHW] : '0;
  // a left shift overflows when shifting back arithmetically fails to restore a
  assign v = (sub == SH_ASL) && (($signed(stg[SHW]) >>> amt) != $signed(a));
endmodule

// File: rtl/alu16_core.sv
module alu16_core
  import alu16_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic [4:0]   op_sel,
  input  logic         carry_in,
  output logic [W-1:0] result,
  output logic         carry_out,
  output logic         flag_v
);
  localparam int SHW = $clog2(W);

  grp_e       grp;
  logic [2:0] sub;
  assign grp = grp_e'(op_sel[4:3]);
  assign sub = op_sel[2:0];

  logic [W-1:0] y_lg, y_cm, y_ar, y_sh;
  logic         h_lg, h_cm, h_ar, h_sh;
  logic         c_ar, v_ar, v_sh;

  alu16_logic_unit #(.W(W)) u_logic (
    .a(op_a), .b(op_b), .sub(sub), .y(y_lg), .hit(h_lg)
  );

  alu16_cmp_unit #(.W(W)) u_cmp (
    .a(op_a), .b(op_b), .sub(sub), .y(y_cm), .hit(h_cm)
  );

  alu16_arith_unit #(.W(W)) u_arith (
    .a(op_a), .b(op_b), .cin(carry_in), .sub(sub),
    .y(y_ar), .cout(c_ar), .v(v_ar), .hit(h_ar)
  );

  alu16_shift_unit #(.W(W)) u_shift (
    .a(op_a), .amt(op_b[SHW-1:0]), .sub(sub),
    .y(y_sh), .v(v_sh), .hit(h_sh)
  );

  logic [W-1:0] y_nx;
  logic         c_nx, v_nx;

  always_comb begin
    y_nx = '0;
    c_nx = 1'b0;
    v_nx = 1'b0;
    case (grp)
      GRP_LOGIC: if (h_lg) y_nx = y_lg;
      GRP_CMP:   if (h_cm) y_nx = y_cm;
      GRP_ARITH: if (h_ar) begin
        y_nx = y_ar;
        c_nx = c_ar;
        v_nx = v_ar;
      end
      GRP_SHIFT: if (h_sh) begin
        y_nx = y_sh;
        v_nx = v_sh;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result    <= '0;
      carry_out <= 1'b0;
      flag_v    <= 1'b0;
    end else begin
      result    <= y_nx;
      carry_out <= c_nx;
      flag_v    <= v_nx;
    end
  end
endmodule

// File: rtl/alu16_core_chk.sv
module alu16_core_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] op_a,
  input logic [W-1:0] op_b,
  input logic [4:0]   op_sel,
  input logic         carry_in,
  input logic [W-1:0] result,
  input logic         carry_out,
  input logic         flag_v
);
  logic undef_sel;
  always_comb begin
    case (op_sel)
      5'b00001, 5'b00010, 5'b00100, 5'b00110,
      5'b01000, 5'b01101,
      5'b10010, 5'b10011,
      5'b11110, 5'b11111: undef_sel = 1'b1;
      default:            undef_sel = 1'b0;
    endcase
  end

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (result == '0 && !carry_out && !flag_v));

  p_no_carry_r10: assert property (@(posedge clk) disable iff (rst)
    (op_sel[4:3] != 2'b10) |=> !carry_out);

  p_cmp_bit_r4: assert property (@(posedge clk) disable iff (rst)
    (op_sel[4:3] == 2'b01) |=> (result[W-1:1] == '0 && !flag_v));

  p_cmp_eq_r4: assert property (@(posedge clk) disable iff (rst)
    (op_sel == 5'b01111 && op_a == op_b) |=> (result == 1));

  p_not_a_r3: assert property (@(posedge clk) disable iff (rst)
    (op_sel == 5'b00000) |=> (result == ~$past(op_a)));

  p_undef_zero_r11: assert property (@(posedge clk) disable iff (rst)
    undef_sel |=> (result == '0 && !carry_out && !flag_v));

  p_rotate_bits_r8: assert property (@(posedge clk) disable iff (rst)
    (op_sel == 5'b11000) |=> ($countones(result) == $countones($past(op_a))));

  p_addu_flag_r5: assert property (@(posedge clk) disable iff (rst)
    (op_sel == 5'b10001) |=> (flag_v == carry_out));
endmodule

bind alu16_core alu16_core_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b), .op_sel(op_sel),
  .carry_in(carry_in), .result(result), .carry_out(carry_out), .flag_v(flag_v)
);

// File: tb/test_alu16_core.sv
module test_alu16_core;
  localparam int PERIOD = 10;
  localparam int LIMIT  = 100000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] op_a = '0, op_b = '0;
  logic [4:0]  op_sel = '0;
  logic        carry_in = 1'b0;
  logic [15:0] result;
  logic        carry_out, flag_v;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  alu16_core i_alu16_core (
    .clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b), .op_sel(op_sel),
    .carry_in(carry_in), .result(result), .carry_out(carry_out), .flag_v(flag_v)
  );

  function automatic bit rng(longint x);
    return (x > 32767) || (x < -32768);
  endfunction

  // behavioural reference from the requirements
  task automatic model(input logic [15:0] a, b, input logic [4:0] sel, input logic ci,
                       output logic [15:0] y, output logic co, output logic v);
    int ua, ub, sa, sb, n, t;
    logic [15:0] r;
    longint p;
    ua = a; ub = b; sa = $signed(a); sb = $signed(b);
    y = '0; co = 1'b0; v = 1'b0;
    case (sel)
      5'b00111: y = a | b;
      5'b00011: y = a ^ b;
      5'b00101: y = a & b;
      5'b00000: y = ~a;
      5'b01001: y = 16'(sa <  sb);
      5'b01100: y = 16'(sa <= sb);
      5'b01011: y = 16'(sa >  sb);
      5'b01110: y = 16'(sa >= sb);
      5'b01111: y = 16'(sa == sb);
      5'b01010: y = 16'(sa != sb);
      5'b10101, 5'b10001: begin
        t = ua + ub + int'(ci); y = t[15:0]; co = t[16];
        v = (sel == 5'b10101) ? rng(longint'(sa) + sb + int'(ci)) : co;
      end
      5'b10100, 5'b10000: begin
        t = ua - ub; y = t[15:0]; co = (ua >= ub);
        v = (sel == 5'b10100) ? rng(longint'(sa) - sb) : (ua < ub);
      end
      5'b10111: begin y = a + 16'd1; co = (ua == 65535); v = (sa == 32767); end
      5'b10110: begin y = a - 16'd1; co = (ua != 0); v = (sa == -32768); end
      5'b11010, 5'b11100, 5'b11011, 5'b11101, 5'b11000, 5'b11001: begin
        n = int'(b[3:0]); r = a;
        for (int i = 0; i < n; i++) begin
          case (sel[2:0])
            3'b010, 3'b100: r = {r[14:0], 1'b0};
            3'b011:         r = {1'b0, r[15:1]};
            3'b101:         r = {r[15], r[15:1]};
            3'b000:         r = {r[14:0], r[15]};
            default:        r = {r[0], r[15:1]};
          endcase
        end
        y = r;
        if (sel == 5'b11100) begin
          p = longint'(sa) * (longint'(1) << n);
          v = rng(p);
        end
      end
      default: ;
    endcase
  endtask

  function automatic string tag_of(logic [4:0] sel);
    case (sel)
      5'b00111, 5'b00011, 5'b00101, 5'b00000: return "R3";
      5'b01001, 5'b01100, 5'b01011, 5'b01110, 5'b01111, 5'b01010: return "R4";
      5'b10101, 5'b10001: return "R5";
      5'b10100, 5'b10000: return "R6";
      5'b10111, 5'b10110: return "R7";
      5'b11100: return "R9";
      5'b11010, 5'b11011, 5'b11101, 5'b11000, 5'b11001: return "R8";
      default: return "R11";
    endcase
  endfunction

  task automatic compare(string tag, logic [15:0] ey, logic ec, logic ev);
    n_vec++;
    if (result !== ey || carry_out !== ec || flag_v !== ev) begin
      n_bad++;
      $display("FAIL %s sel=%b a=%h b=%h ci=%b : got y=%h c=%b v=%b expected y=%h c=%b v=%b",
               tag, op_sel, op_a, op_b, carry_in, result, carry_out, flag_v, ey, ec, ev);
    end
  endtask

  // drive at the falling edge; registered outputs are valid at the next falling edge
  task automatic apply(string tag, logic [15:0] a, b, logic [4:0] sel, logic ci);
    logic [15:0] ey;
    logic ec, ev;
    op_a = a; op_b = b; op_sel = sel; carry_in = ci;
    model(a, b, sel, ci, ey, ec, ev);
    @(negedge clk);
    compare(tag, ey, ec, ev);
  endtask

  logic [15:0] corner [8] = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000,
                              16'hFFFF, 16'h5555, 16'hAAAA, 16'h0010};

  initial begin
    repeat (3) @(negedge clk);
    compare("R1", '0, 1'b0, 1'b0);     // R1: reset state
    rst = 1'b0;

    // R2: same operands routed through one member of each family
    apply("R2", 16'h1234, 16'h00F3, 5'b00111, 1'b0);
    apply("R2", 16'h1234, 16'h00F3, 5'b01001, 1'b0);
    apply("R2", 16'h1234, 16'h00F3, 5'b10101, 1'b0);
    apply("R2", 16'h1234, 16'h00F3, 5'b11010, 1'b0);

    // every selector code across corner operands and both carries
    for (int s = 0; s < 32; s++)
      for (int i = 0; i < 8; i++)
        for (int j = 0; j < 8; j++)
          for (int c = 0; c < 2; c++)
            apply(tag_of(5'(s)), corner[i], corner[j], 5'(s), 1'(c));

    // R6/R7: carry_in ignored by subtract, increment, decrement
    apply("R6", 16'h0005, 16'h0003, 5'b10000, 1'b1);
    apply("R6", 16'h8000, 16'h0001, 5'b10100, 1'b1);
    apply("R7", 16'h7FFF, 16'hFFFF, 5'b10111, 1'b1);
    apply("R7", 16'h0000, 16'h1234, 5'b10110, 1'b1);

    // R8: upper bits of the amount are ignored
    apply("R8", 16'h8421, 16'hFFF3, 5'b11010, 1'b0);
    apply("R8", 16'h8421, 16'h0F05, 5'b11101, 1'b0);
    apply("R8", 16'h8421, 16'hA0F1, 5'b11001, 1'b0);
    apply("R9", 16'h2000, 16'h0001, 5'b11100, 1'b0);
    apply("R9", 16'h2000, 16'h0002, 5'b11100, 1'b0);
    apply("R9", 16'hC000, 16'h0001, 5'b11100, 1'b0);

    // R10: flags stay clear in logic and compare families with carry_in high
    for (int s = 0; s < 16; s++)
      apply("R10", 16'hFFFF, 16'hFFFF, 5'(s), 1'b1);

    // random operands on every code
    for (int k = 0; k < 100; k++)
      for (int s = 0; s < 32; s++)
        apply(tag_of(5'(s)), 16'($urandom), 16'($urandom), 5'(s), 1'($urandom));

    // R1: reset in mid-run clears a non-zero result
    apply("R1", 16'hFFFF, 16'h0001, 5'b10001, 1'b1);
    rst = 1'b1;
    @(negedge clk);
    compare("R1", '0, 1'b0, 1'b0);
    rst = 1'b0;

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (LIMIT) @(posedge clk);
    if (!done) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: run did not finish, got timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule